// File: doc/BRIEF.md
# FIFO Occupancy Interrupt Event Generator

This block turns the state of a receive FIFO and a transmit FIFO into host interrupt requests. It samples the two occupancy counts and the push strobes every clock, and from them it detects four events. One event fires for every received byte. Two receive events are one-shots that re-arm only after the FIFO condition that caused them has gone away: one for "data has arrived" and one for "nearly full". A transmit one-shot reports that the transmit FIFO has drained.

Each event sets a sticky flag, and the flag stays set until the host clears it with a write-one-to-clear strobe. A per-event enable mask chooses which flags drive the single active-high interrupt line. The flags are set whatever the mask holds, so a host can poll the flags with every enable off, or take interrupts on any subset of events. The FIFOs are not part of this block. Their counts are inputs here.

Top module: `irq_buf_events`

## Requirements
- R1: Every cycle with `rx_push` high sets flag bit 0 (byte received) at the next clock edge.
- R2: Flag bit 1 (receive not empty) is set when `rx_count` is non-zero while its event is armed. Firing disarms the event. It re-arms only in a cycle where `rx_count` is zero, so one fill of the FIFO raises it once.
- R3: Flag bit 2 (receive nearly full) is set when `rx_count` is at least floor(3*DEPTH/4) while armed. Firing disarms it. It re-arms only when `rx_count` falls to floor(DEPTH/4) or below, so values between the two levels neither fire nor re-arm it. With DEPTH=16 the levels are 12 and 4.
- R4: Flag bit 3 (transmit empty) is armed by any cycle with `tx_push` high. It fires when armed, `tx_count` is zero and `tx_push` is low. Firing disarms it.
- R5: Flags are sticky. A cycle with `clr_we` high clears each flag whose `clr_bits` bit is 1. An event in that same cycle keeps its flag set.
- R6: `irq_o` is the OR of the flags that are both set and enabled in `evt_en`, using the same bit positions. `evt_en` has no effect on whether flags get set.
- R7: While `rst` is high at a clock edge, all flags and `irq_o` go to 0. After reset the two receive one-shots are armed and the transmit one-shot is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_push | input | 1 | A byte enters the receive FIFO this cycle |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| tx_push | input | 1 | A byte enters the transmit FIFO this cycle |
| evt_en | input | 4 | Per-event interrupt enable |
| clr_we | input | 1 | Flag clear strobe |
| clr_bits | input | 4 | Write-one-to-clear mask |
| flags_o | output | 4 | Sticky event flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench targets these corner cases. Each item says what a faulty design would do.

- **Nearly-full threshold edges.** The bench drives the count to 11 and to 12, and it drops back to 5 and to 4 before refilling. A design with a threshold off by one, or that re-armed without hysteresis, would fire at the wrong count or fire twice in one fill.
- **Not-empty one-shot.** The bench lets the receive FIFO refill without ever reaching zero. A not-empty event that re-armed on a pop instead of on empty would raise its flag again.
- **Clear in the same cycle as an event.** The bench pushes a byte in the cycle that clears flag bit 0. A design that gave the clear priority would lose that event.
- **Transmit-empty arming.** The bench holds the transmit FIFO empty straight after reset. A design armed at reset would raise bit 3 there.
- **Enable mask.** Random enable masks are applied and compared with a reference model. A design that gated the flags instead of the request would fail this comparison.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

    localparam int NUM_EVT = 4;

    // Flag bit positions (the host decodes these)
    typedef enum int unsigned {
        EVT_RX_BYTE     = 0,
        EVT_RX_NONEMPTY = 1,
        EVT_RX_HIGH     = 2,
        EVT_TX_EMPTY    = 3
    } evt_idx_e;

    typedef struct packed {
        logic tx_empty;
        logic rx_high;
        logic rx_nonempty;
        logic rx_byte;
    } evt_vec_t;

    // Nearly-full level: three quarters of capacity
    function automatic int unsigned hi_mark(int unsigned depth);
        return (depth * 3) / 4;
    endfunction

    // Re-arm level for nearly-full: one quarter of capacity
    function automatic int unsigned lo_mark(int unsigned depth);
        return depth / 4;
    endfunction

    // Receive one-shots start armed, the transmit one waits for a push
    function automatic bit arm_at_reset(int unsigned idx);
        return (idx == int'(EVT_TX_EMPTY)) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/irq_oneshot.sv
module irq_oneshot #(
    parameter bit ARM_INIT = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_cond_i,
    input  logic rearm_cond_i,
    output logic fire_o
);

    logic armed_q;

    assign fire_o = armed_q & fire_cond_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= ARM_INIT;
        end else if (fire_o) begin
            armed_q <= 1'b0;
        end else if (rearm_cond_i) begin
            armed_q <= 1'b1;
        end
    end

    // R2 R3 R4: after firing, a one-shot needs a re-arm before it can fire again
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (rst)
        fire_o && !rearm_cond_i |=> !fire_o || $past(rearm_cond_i)) else $error("refire without rearm"); // R2

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] en_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);

    logic [N-1:0] flags_q;
    logic [N-1:0] clr_mask;

    assign clr_mask = clr_we ? clr_bits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            // a new event outranks a clear in the same cycle
            flags_q <= (flags_q & ~clr_mask) | evt_i;
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & en_i);

    for (genvar i = 0; i < N; i++) begin : g_chk
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
            flags_q[i] && !(clr_we && clr_bits[i]) |=> flags_q[i]) else $error("flag dropped"); // R5
        AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
            clr_we && clr_bits[i] && !evt_i[i] |=> !flags_q[i]) else $error("clear ignored"); // R5
        AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
            evt_i[i] |=> flags_q[i]) else $error("event lost"); // R5
    end

endmodule

// File: rtl/irq_buf_events.sv
module irq_buf_events
    import irq_evt_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic               rx_push,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               tx_push,
    input  logic [NUM_EVT-1:0] evt_en,
    input  logic               clr_we,
    input  logic [NUM_EVT-1:0] clr_bits,
    output logic [NUM_EVT-1:0] flags_o,
    output logic               irq_o
);

    localparam logic [CNT_W-1:0] HI_LVL = CNT_W'(hi_mark(DEPTH));
    localparam logic [CNT_W-1:0] LO_LVL = CNT_W'(lo_mark(DEPTH));

    logic [NUM_EVT-1:1] fire_cond;
    logic [NUM_EVT-1:1] rearm_cond;
    evt_vec_t           evt;

    initial begin
        AST_DEPTH_OK: assert (DEPTH >= 4) else $error("DEPTH too small"); // R3
    end

    always_comb begin
        fire_cond  = '0;
        rearm_cond = '0;
        fire_cond[EVT_RX_NONEMPTY]  = (rx_count != '0);
        rearm_cond[EVT_RX_NONEMPTY] = (rx_count == '0);
        fire_cond[EVT_RX_HIGH]      = (rx_count >= HI_LVL);
        rearm_cond[EVT_RX_HIGH]     = (rx_count <= LO_LVL);
        fire_cond[EVT_TX_EMPTY]     = (tx_count == '0) && !tx_push;
        rearm_cond[EVT_TX_EMPTY]    = tx_push;
    end

    assign evt.rx_byte = rx_push;

    logic [NUM_EVT-1:1] shot;

    for (genvar i = 1; i < NUM_EVT; i++) begin : g_shot
        irq_oneshot #(
            .ARM_INIT (arm_at_reset(i))
        ) u_shot (
            .clk          (clk),
            .rst          (rst),
            .fire_cond_i  (fire_cond[i]),
            .rearm_cond_i (rearm_cond[i]),
            .fire_o       (shot[i])
        );
    end

    assign evt.rx_nonempty = shot[EVT_RX_NONEMPTY];
    assign evt.rx_high     = shot[EVT_RX_HIGH];
    assign evt.tx_empty    = shot[EVT_TX_EMPTY];

    irq_flag_bank #(
        .N (NUM_EVT)
    ) u_flags (
        .clk      (clk),
        .rst      (rst),
        .evt_i    (evt),
        .clr_we   (clr_we),
        .clr_bits (clr_bits),
        .en_i     (evt_en),
        .flags_o  (flags_o),
        .irq_o    (irq_o)
    );

    AST_BYTE_FLAG: assert property (@(posedge clk) disable iff (rst)
        rx_push |=> flags_o[EVT_RX_BYTE]) else $error("byte flag missing"); // R1
    AST_NE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[EVT_RX_NONEMPTY]) |-> $past(rx_count) != '0) else $error("nonempty from empty"); // R2
    AST_HIGH_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[EVT_RX_HIGH]) |-> $past(rx_count) >= HI_LVL) else $error("high below level"); // R3
    AST_TXE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_o[EVT_TX_EMPTY]) |-> $past(tx_count) == '0 && !$past(tx_push)) else $error("txe not empty"); // R4
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> evt_en != '0) else $error("irq while all disabled"); // R6

endmodule

// File: tb/irq_buf_events_tb.sv
module irq_buf_events_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int CW         = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] HI = CW'(12);
    localparam logic [CW-1:0] LO = CW'(4);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] rx_count, tx_count;
    logic          rx_push, tx_push;
    logic [3:0]    evt_en, clr_bits, flags_o;
    logic          clr_we, irq_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // reference model state
    logic       m_ne, m_hi, m_tx;
    logic [3:0] m_flags;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cycles++;

    irq_buf_events #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .rx_count(rx_count), .rx_push(rx_push),
        .tx_count(tx_count), .tx_push(tx_push), .evt_en(evt_en),
        .clr_we(clr_we), .clr_bits(clr_bits), .flags_o(flags_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic string bit_req(int b);
        case (b)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Apply current inputs for one clock, update model, compare outputs.
    task automatic step();
        logic [3:0] ev;
        ev[0] = rx_push;
        ev[1] = m_ne && (rx_count != '0);
        ev[2] = m_hi && (rx_count >= HI);
        ev[3] = m_tx && (tx_count == '0) && !tx_push;
        m_ne = ev[1] ? 1'b0 : ((rx_count == '0) ? 1'b1 : m_ne);
        m_hi = ev[2] ? 1'b0 : ((rx_count <= LO) ? 1'b1 : m_hi);
        m_tx = ev[3] ? 1'b0 : (tx_push ? 1'b1 : m_tx);
        m_flags = (m_flags & ~(clr_we ? clr_bits : 4'b0)) | ev;
        @(posedge clk);
        #1;
        for (int b = 0; b < 4; b++)
            check(bit_req(b), {3'b0, flags_o[b]}, {3'b0, m_flags[b]});
        check("R6", {3'b0, irq_o}, {3'b0, |(m_flags & evt_en)});
    endtask

    task automatic idle();
        rx_push = 1'b0; tx_push = 1'b0; clr_we = 1'b0; clr_bits = '0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        rst = 1'b0;
        m_ne = 1'b1; m_hi = 1'b1; m_tx = 1'b0; m_flags = '0;
        check("R7", flags_o, 4'b0);
        check("R7", {3'b0, irq_o}, 4'b0);
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_bits = 4'hF; step(); idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        rx_count = '0; tx_count = '0; evt_en = 4'hF;
        do_reset();

        // R7/R4: transmit one-shot disarmed after reset despite empty FIFO
        step(); step();
        check("R4", {3'b0, flags_o[3]}, 4'b0);

        // R3 threshold edges
        rx_count = CW'(11); step();
        check("R3", {3'b0, flags_o[2]}, 4'b0);
        rx_count = HI; step();
        check("R3", {3'b0, flags_o[2]}, 4'b1);
        clear_all();
        rx_count = CW'(5); step();
        rx_count = HI; step();
        check("R3", {3'b0, flags_o[2]}, 4'b0);
        rx_count = LO; step();
        rx_count = HI; step();
        check("R3", {3'b0, flags_o[2]}, 4'b1);

        // R2: refill without reaching zero does not re-fire
        clear_all();
        rx_count = CW'(1); step(); step();
        check("R2", {3'b0, flags_o[1]}, 4'b0);
        rx_count = '0; step();
        rx_count = CW'(2); step();
        check("R2", {3'b0, flags_o[1]}, 4'b1);

        // R5: push in the clearing cycle keeps bit 0
        rx_push = 1'b1; step(); idle();
        clr_we = 1'b1; clr_bits = 4'b0001; rx_push = 1'b1; step(); idle();
        check("R5", {3'b0, flags_o[0]}, 4'b1);
        clr_we = 1'b1; clr_bits = 4'b0001; step(); idle();
        check("R5", {3'b0, flags_o[0]}, 4'b0);

        // R6: masked flags still set, no request
        evt_en = 4'b0; rx_push = 1'b1; step(); idle();
        check("R6", {3'b0, flags_o[0]}, 4'b1);
        check("R6", {3'b0, irq_o}, 4'b0);
        evt_en = 4'b0001; #1;
        check("R6", {3'b0, irq_o}, 4'b1);

        // R4: arm by push, fire on drain
        tx_count = '0; tx_push = 1'b1; step(); idle();
        tx_count = CW'(1); step();
        tx_count = '0; step();
        check("R4", {3'b0, flags_o[3]}, 4'b1);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            idle();
            if (rx_count < FULL && ($urandom % 2) == 0) rx_push = 1'b1;
            if (tx_count < FULL && ($urandom % 3) == 0) tx_push = 1'b1;
            if (($urandom % 6) == 0) begin clr_we = 1'b1; clr_bits = 4'($urandom); end
            if (($urandom % 8) == 0) evt_en = 4'($urandom);
            step();
            if (rx_push) rx_count = rx_count + 1'b1;
            if (rx_count != '0 && ($urandom % 5) < 2) rx_count = rx_count - 1'b1;
            if (tx_push) tx_count = tx_count + 1'b1;
            if (tx_count != '0 && ($urandom % 2) == 0) tx_count = tx_count - 1'b1;
            if (($urandom % 300) == 0) rx_count = '0;
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule